// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external SPI master read and write a bank of byte-wide control registers. Every access is one frame framed by an active-low select. The frame carries a direction flag, a register address, some padding bits and one or more data bytes, all most significant bit first. The serial pins are brought into the system clock domain through synchronizer chains, and the serial clock edges are detected there. The block then talks to the register bank through a plain parallel port: an address, a decode-valid input, read data, write data and a one-cycle write strobe.

The data output carries both a value and an enable, and the enable low stands for high impedance. The output is enabled only for reads of an address that the register bank decodes. When it is enabled, it is held low through the padding bits, ahead of the data. Reads and writes that continue past the first byte move the address pointer up by one per byte, but only while the pointer lies inside a fixed window. Once the pointer steps off the top of that window, the read output is released and further write bytes are dropped.

The master's serial clock high and low phases must each last at least six system clock cycles. This gives room for the synchronizer latency, so the output settles before the master samples it.

Top module: `spi_regport`

## Requirements
- R1: A frame is, in order: one direction bit (1 means read, 0 means write), ADDR_W address bits sent MSB first, PAD_W padding bits, then DATA_W-bit data bytes sent MSB first. The master changes data on falling serial clock edges and the block samples it on rising edges. After the last address bit, `reg_addr_o` holds the address that was sent.
- R2: `spi_miso_oe_o` stays low while the direction bit, the address bits and the first padding bit are received. It also stays low for the whole of every write frame and of every read of an address with `reg_hit_i` low.
- R3: For a read of a decoded address, `spi_miso_oe_o` rises with `spi_miso_o` low at the first rising serial clock edge after the first padding bit. The output stays low until the data phase begins.
- R4: In a read, each data byte is the `reg_rdata_i` of the current address, shifted out MSB first. The output changes after falling serial clock edges, so each bit is stable at the following rising edge.
- R5: After each completed data byte, if the pointer lies within WIN_LO..WIN_HI (default 0x200..0x227), the pointer increases by one. The next byte then comes from that new address.
- R6: A frame whose start address lies outside WIN_LO..WIN_HI never moves the pointer. In such a frame, every byte refers to the start address.
- R7: Once the pointer has stepped past WIN_HI, `spi_miso_oe_o` stays low for the rest of the frame.
- R8: In a write frame, each completed data byte gives exactly one single-cycle `reg_wr_o` pulse, with that byte on `reg_wdata_o` and the current address on `reg_addr_o`. The pulse is given only when `reg_hit_i` is high and the pointer has not passed WIN_HI.
- R9: Raising `spi_csn_i` at any point ends the frame. The output enable drops, a partly received byte gives no write, and the next frame starts again from its direction bit.
- R10: After reset, `spi_miso_oe_o` and `reg_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from the master |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| spi_miso_oe_o | output | 1 | Output enable for spi_miso_o (low means high impedance) |
| reg_addr_o | output | ADDR_W | Register pointer |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data byte |
| reg_rdata_i | input | DATA_W | Read data at reg_addr_o |
| reg_hit_i | input | 1 | reg_addr_o decodes to a register |

## Verification
The bound checker watches these rules on every cycle:
- The enable never rises before the padding bits have arrived.
- The enable appears only in read frames, and it falls in the cycle after the select drops or the pointer leaves the window.
- A write strobe lasts one cycle and never occurs in a read frame.
- The pointer moves by exactly one, and only inside the window.

Some behaviour only the bench scenarios can show:
- the exact bit values shifted out;
- that the pointer moves at byte boundaries;
- the repeated bytes when a frame starts below the window;
- the strobes at the top of the window;
- the loss of a partial byte on abort.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   // synchronised serial pins, packed in a fixed order for the sync chain
   typedef struct packed {
      logic sclk;
      logic csn;
      logic mosi;
   } pin_bus_t;

   localparam int PIN_W = $bits(pin_bus_t);

   // idle level of the pins while reset: select high, clock and data low
   localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regport_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter int PAD_W  = 5,
   parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'('h200),
   parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'('h227),
   localparam int HDR_BITS = 1 + ADDR_W + PAD_W,
   localparam int HC_W     = $clog2(HDR_BITS + 1),
   localparam int BC_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              mosi,
   input  logic              reg_hit_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_o,
   output logic [HC_W-1:0]   hdr_cnt_o,
   output logic [BC_W-1:0]   bit_cnt_o,
   output logic              in_data_o,
   output logic              step_o,
   output logic              past_o,
   output logic              wr_o,
   output logic [DATA_W-1:0] wdata_o
);

   localparam logic [HC_W-1:0] HDR_END  = HC_W'(HDR_BITS);
   localparam logic [HC_W-1:0] ADDR_END = HC_W'(ADDR_W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

   if (DATA_W < 2 || ADDR_W < 2) begin : g_bad_width
      $error("spi_regport_frame: ADDR_W and DATA_W must be at least 2");
   end
   if (WIN_LO > WIN_HI) begin : g_bad_window
      $error("spi_regport_frame: WIN_LO above WIN_HI");
   end

   logic [DATA_W-1:0] shreg;
   logic              in_win;

   assign in_data_o = (hdr_cnt_o == HDR_END);
   assign in_win    = (addr_o >= WIN_LO) && (addr_o <= WIN_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o    <= '0;
         rd_o      <= 1'b0;
         hdr_cnt_o <= '0;
         bit_cnt_o <= '0;
         step_o    <= 1'b0;
         past_o    <= 1'b0;
         wr_o      <= 1'b0;
         wdata_o   <= '0;
         shreg     <= '0;
      end else if (!cs_act) begin
         rd_o      <= 1'b0;
         hdr_cnt_o <= '0;
         bit_cnt_o <= '0;
         step_o    <= 1'b0;
         past_o    <= 1'b0;
         wr_o      <= 1'b0;
         shreg     <= '0;
      end else begin
         step_o <= 1'b0;
         wr_o   <= 1'b0;
         if (sclk_rise) begin
            if (!in_data_o) begin
               hdr_cnt_o <= hdr_cnt_o + 1'b1;
               if (hdr_cnt_o == '0)            rd_o   <= mosi;
               else if (hdr_cnt_o <= ADDR_END) addr_o <= {addr_o[ADDR_W-2:0], mosi};
            end else begin
               shreg <= {shreg[DATA_W-2:0], mosi};
               if (bit_cnt_o == LAST_BIT) begin
                  bit_cnt_o <= '0;
                  step_o    <= 1'b1;
                  wdata_o   <= {shreg[DATA_W-2:0], mosi};
                  wr_o      <= !rd_o && !past_o && reg_hit_i;
               end else begin
                  bit_cnt_o <= bit_cnt_o + 1'b1;
               end
            end
         end
         // pointer advances the cycle after a byte closes, once the strobe is out
         if (step_o && in_win) begin
            addr_o <= addr_o + 1'b1;
            if (addr_o == WIN_HI) past_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter int PAD_W  = 5,
   localparam int HDR_BITS = 1 + ADDR_W + PAD_W,
   localparam int HC_W     = $clog2(HDR_BITS + 1),
   localparam int BC_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic [HC_W-1:0]   hdr_cnt,
   input  logic [BC_W-1:0]   bit_cnt,
   input  logic              in_data,
   input  logic              rd,
   input  logic              past,
   input  logic              reg_hit_i,
   input  logic [DATA_W-1:0] reg_rdata_i,
   output logic              miso_o,
   output logic              oe_o
);

   // the rising edge that follows the first padding bit
   localparam logic [HC_W-1:0] EARLY_AT = HC_W'(ADDR_W + 2);

   if (PAD_W < 2) begin : g_bad_pad
      $error("spi_regport_tx: PAD_W must be at least 2");
   end

   logic [DATA_W-1:0] snap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_o   <= 1'b0;
         miso_o <= 1'b0;
         snap   <= '0;
      end else if (!cs_act || past) begin
         oe_o   <= 1'b0;
         miso_o <= 1'b0;
      end else begin
         if (sclk_rise && hdr_cnt == EARLY_AT && rd && reg_hit_i) begin
            oe_o   <= 1'b1;
            miso_o <= 1'b0;
         end
         if (sclk_fall && in_data) begin
            if (bit_cnt == '0) begin
               miso_o <= reg_rdata_i[DATA_W-1];
               snap   <= reg_rdata_i << 1;
            end else begin
               miso_o <= snap[DATA_W-1];
               snap   <= snap << 1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PAD_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'('h200),
   parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'('h227)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk_i,
   input  logic              spi_csn_i,
   input  logic              spi_mosi_i,
   output logic              spi_miso_o,
   output logic              spi_miso_oe_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_wr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   input  logic              reg_hit_i
);

   localparam int HDR_BITS = 1 + ADDR_W + PAD_W;
   localparam int HC_W     = $clog2(HDR_BITS + 1);
   localparam int BC_W     = $clog2(DATA_W);

   pin_bus_t          pins_raw, pins_s;
   logic              sclk_q, sclk_rise, sclk_fall, cs_act;
   logic [HC_W-1:0]   hdr_cnt;
   logic [BC_W-1:0]   bit_cnt;
   logic              in_data, rd, step, past;

   assign pins_raw = '{sclk: spi_sclk_i, csn: spi_csn_i, mosi: spi_mosi_i};

   spi_regport_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_IDLE)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= pins_s.sclk;
   end

   assign sclk_rise = pins_s.sclk & ~sclk_q;
   assign sclk_fall = ~pins_s.sclk & sclk_q;
   assign cs_act    = ~pins_s.csn;

   spi_regport_frame #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAD_W(PAD_W),
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .sclk_rise(sclk_rise),
      .mosi     (pins_s.mosi),
      .reg_hit_i(reg_hit_i),
      .addr_o   (reg_addr_o),
      .rd_o     (rd),
      .hdr_cnt_o(hdr_cnt),
      .bit_cnt_o(bit_cnt),
      .in_data_o(in_data),
      .step_o   (step),
      .past_o   (past),
      .wr_o     (reg_wr_o),
      .wdata_o  (reg_wdata_o)
   );

   spi_regport_tx #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAD_W(PAD_W)
   ) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .hdr_cnt    (hdr_cnt),
      .bit_cnt    (bit_cnt),
      .in_data    (in_data),
      .rd         (rd),
      .past       (past),
      .reg_hit_i  (reg_hit_i),
      .reg_rdata_i(reg_rdata_i),
      .miso_o     (spi_miso_o),
      .oe_o       (spi_miso_oe_o)
   );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
   parameter int ADDR_W = 10,
   parameter int PAD_W  = 5,
   parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'('h200),
   parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'('h227),
   localparam int HC_W = $clog2(1 + ADDR_W + PAD_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              oe,
   input logic              rd,
   input logic              wr,
   input logic              step,
   input logic              past,
   input logic [ADDR_W-1:0] addr,
   input logic [HC_W-1:0]   hdr_cnt
);

   localparam logic [HC_W-1:0] FIRST_OE = HC_W'(ADDR_W + 3);

   a_r2_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> hdr_cnt >= FIRST_OE);

   a_r3_read_only_drive: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> rd);

   a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cs_act && addr >= WIN_LO && addr <= WIN_HI) |=> addr == $past(addr) + 1'b1);

   a_r6_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cs_act && (addr < WIN_LO || addr > WIN_HI)) |=> $stable(addr));

   a_r7_float_after_top: assert property (@(posedge clk) disable iff (!rst_n)
      past |=> !oe);

   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !wr);

   a_r8_strobe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !rd);

   a_r9_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !oe);

endmodule

bind spi_regport spi_regport_chk #(
   .ADDR_W(ADDR_W), .PAD_W(PAD_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_act (cs_act),
   .oe     (spi_miso_oe_o),
   .rd     (rd),
   .wr     (reg_wr_o),
   .step   (step),
   .past   (past),
   .addr   (reg_addr_o),
   .hdr_cnt(hdr_cnt)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;

   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic       miso, oe, wr, hit;
   logic [9:0] raddr;
   logic [7:0] wdata, rdata;

   int checks = 0;
   int bad    = 0;
   bit done   = 0;

   logic [17:0] exp_q[$];

   always #2 clk = ~clk;

   function automatic logic hit_f(input logic [9:0] a);
      return (a < 10'h0A0) || (a >= 10'h200 && a <= 10'h22F);
   endfunction

   function automatic logic [7:0] rd_f(input logic [9:0] a);
      return a[7:0] ^ 8'h5A ^ {a[9:8], 6'b0};
   endfunction

   assign hit   = hit_f(raddr);
   assign rdata = rd_f(raddr);

   spi_regport i_spi_regport (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk_i(sclk), .spi_csn_i(csn), .spi_mosi_i(mosi),
      .spi_miso_o(miso), .spi_miso_oe_o(oe),
      .reg_addr_o(raddr), .reg_wr_o(wr), .reg_wdata_o(wdata),
      .reg_rdata_i(rdata), .reg_hit_i(hit)
   );

   task automatic chk(input string tag, input string what,
                      input logic [17:0] act, input logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: every write strobe is popped from the scoreboard (R8)
   always @(negedge clk) begin
      if (rst_n && wr) begin
         if (exp_q.size() == 0) chk("R8", "unexpected strobe", {raddr, wdata}, 18'h0);
         else chk("R8", "strobe addr/data", {raddr, wdata}, exp_q.pop_front());
      end
   end

   task automatic frame(input logic rd, input logic [9:0] start,
                        input int nbytes, input int extra, input logic [7:0] seed);
      bit   inwin = (start >= 10'h200) && (start <= 10'h227);
      logic vr    = rd && hit_f(start);
      int   total = 16 + 8 * nbytes + extra;
      if (!rd) begin
         for (int m = 0; m < nbytes; m++) begin
            logic [9:0] a = inwin ? start + 10'(m) : start;
            bit past = inwin && (a > 10'h227);
            if (!past && hit_f(a)) exp_q.push_back({a, seed + 8'(m * 29)});
         end
      end
      csn = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         int m = (i - 16) / 8;
         int k = (i - 16) % 8;
         logic [7:0] byt = seed + 8'(m * 29);
         logic [9:0] a = inwin ? start + 10'(m) : start;
         bit past = inwin && (a > 10'h227);
         logic eoe = vr && !past;
         logic [7:0] rb = rd_f(a);
         string tag;
         if (i == 0)       mosi = rd;
         else if (i <= 10) mosi = start[10-i];
         else if (i < 16)  mosi = 1'b0;
         else              mosi = byt[7-k];
         repeat (H) @(negedge clk);
         if (i < 13) chk("R2", "oe in header", 18'(oe), 18'(0));
         else if (i < 16) begin
            chk(vr ? "R3" : "R2", "oe in padding", 18'(oe), 18'(vr));
            if (vr) chk("R3", "miso low in padding", 18'(miso), 18'(0));
            if (i == 13) chk("R1", "decoded address", 18'(raddr), 18'(start));
         end else begin
            if (!vr)                  tag = "R2";
            else if (past)            tag = "R7";
            else if (m > 0 && inwin)  tag = "R5";
            else if (m > 0)           tag = "R6";
            else                      tag = "R4";
            chk(tag, "oe in data", 18'(oe), 18'(eoe));
            if (eoe) chk(tag, "miso data bit", 18'(miso), 18'(rb[7-k]));
         end
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      csn = 1'b1;
      repeat (3 * H) @(negedge clk);
      chk("R9", "oe after deselect", 18'(oe), 18'(0));
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_up();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10", "oe after reset", 18'(oe), 18'(0));
      chk("R10", "strobe after reset", 18'(wr), 18'(0));

      frame(1'b1, 10'h200, 3, 0, 8'h00);   // R5 burst read inside window
      frame(1'b1, 10'h226, 4, 0, 8'h00);   // R7 read across top of window
      frame(1'b1, 10'h005, 3, 0, 8'h00);   // R6 read below window repeats
      frame(1'b1, 10'h150, 2, 0, 8'h00);   // R2 undecoded read floats
      frame(1'b0, 10'h225, 4, 0, 8'h3C);   // R8 write burst, last byte past top
      frame(1'b0, 10'h010, 3, 0, 8'hA1);   // R6/R8 write below window
      frame(1'b0, 10'h150, 2, 0, 8'h77);   // R8 undecoded write, no strobe
      frame(1'b0, 10'h203, 1, 5, 8'hE4);   // R9 abort with partial byte
      frame(1'b1, 10'h210, 0, 4, 8'h00);   // R9 abort read mid byte
      frame(1'b1, 10'h201, 2, 0, 8'h00);   // R9 fresh frame after aborts

      repeat (4 * H) @(negedge clk);
      chk("R9", "scoreboard drained", 18'(exp_q.size()), 18'(0));
      finish_up();
   end

endmodule